// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A cycle-accurate, synthesizable model of a synchronous static RAM whose write data trails its address by one or two clocks. Because the data for a write is taken on a later edge, a read can follow a write, and a write can follow a read, on consecutive clocks with no idle cycle on the shared data bus. A static mode input selects between two variants. The pipelined variant has an output register and takes write data two edges after the address. The flow-through variant drives read data in the cycle right after the address edge and takes write data one edge after the address.

All control is sampled on the rising clock edge, and only on edges where the clock enable is high. A started access can be continued as a four-beat burst by raising the advance input. The burst walks the two low address bits in linear or interleaved order and keeps the read or write type of its first beat. Each 9-bit byte has its own write enable, and its parity is checked when its data is captured. The data outputs can be switched off at once by an asynchronous output enable or by the sleep input. The storage array is internal and small.

Top module: `zt_sram`

## Requirements
- R1: The device is selected only when `en0_n`=0, `en1`=1 and `en2_n`=0 at a command edge with `adv`=0. Any other combination is a deselect, and no read data is driven for that command.
- R2: Pipelined mode (`flow_mode`=0): read data for a command sampled at enabled edge n is driven, with `rd_drive`=1, from enabled edge n+1 until edge n+2. Nothing is driven after reset.
- R3: Flow-through mode (`flow_mode`=1): read data for a command sampled at edge n is driven right after edge n, and only until the next enabled edge.
- R4: Pipelined mode: the write data for a write command sampled at enabled edge n is taken from `wdata` at enabled edge n+2.
- R5: Flow-through mode: the write data for a write command sampled at enabled edge n is taken from `wdata` at enabled edge n+1.
- R6: A pipelined read of a word, issued on the enabled edge right after a write to that word, returns the new data in the enabled byte lanes, even though that data arrives on the same edge that loads the output register.
- R7: With `lin_order`=1, a burst that starts at low address bits b visits (b+k) mod 4 for beats k=0..3. The upper address bits stay fixed.
- R8: With `lin_order`=0, a burst that starts at low address bits b visits b XOR k for beats k=0..3.
- R9: While `adv`=1 and a burst is active, each enabled edge runs the next beat with the read/write type of the first beat. `we`, `addr` and the three enables are ignored. `adv`=1 with no active burst acts as a deselect.
- R10: Byte lane i (`wdata` bits 9i+8..9i) is written only when `byte_we[i]`=1 at the command edge of that beat. Disabled lanes keep their old contents.
- R11: At each write-data capture edge, `par_err` is set to 1 for the following cycle if an enabled lane has an XOR over its 9 bits that differs from `par_odd` (0 = even, 1 = odd). Disabled lanes are not checked. Otherwise the flag is 0.
- R12: An edge with `clk_en`=0 changes no state. Commands on it are lost, and outputs hold their values.
- R13: `oe_n`=1 forces `rd_drive` to 0 and `rdata` to 0 at once, without waiting for a clock edge.
- R14: `sleep`=1 turns off the data outputs at once, and any command sampled while it is high is treated as a deselect that also ends a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable; low freezes the device |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| we | input | 1 | 1 = write, 0 = read on a new command |
| adv | input | 1 | Continue the active burst |
| byte_we | input | 2 | Per-lane write enables |
| addr | input | 6 | Word address |
| wdata | input | 18 | Late write data, two 9-bit lanes |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Deselects the device and turns the outputs off |
| flow_mode | input | 1 | 1 = flow-through, 0 = pipelined (static) |
| lin_order | input | 1 | 1 = linear burst, 0 = interleaved (static) |
| par_odd | input | 1 | Parity sense: 1 = odd, 0 = even |
| rdata | output | 18 | Read data, zero when not driven |
| rd_drive | output | 1 | High while the data bus is driven |
| par_err | output | 1 | Write parity error for the last capture |

## Verification
The bench targets the timing of the late-write data. It uses back-to-back write-then-read streams in both modes. A design that takes data on the wrong edge would store the previous or next beat's value. A pipelined read right after a partial write to the same word would return stale lanes if the forwarding were missing or ignored the lane enables. The bench runs bursts in both orders with `we` and the enables toggled during the beats: a wrong offset function reads the wrong words, and a design that re-decodes commands mid-burst would switch type. It also covers parity on disabled lanes and the odd/even sense, frozen edges that must neither load a queued read nor drop held data, and the asynchronous output gates.

// File: rtl/zt_pkg.sv
// Shared types and helpers for the zero-turnaround SRAM model.
// Assumes the burst always spans the two least significant address bits.
package zt_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    // Low address bits of burst beat cnt, starting from base offset.
    function automatic logic [1:0] burst_offset(input logic [1:0] base,
                                                input logic [1:0] cnt,
                                                input logic       lin);
        return lin ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/zt_burst_ctl.sv
// Command decoder and burst address generator.
// Samples the control inputs on each enabled edge and presents one resolved
// beat (operation, word address, lane enables) for the cycle that follows.
// Assumes ADDR_W >= 3 and that lin_order is static.
module zt_burst_ctl
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTE  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              sleep,
    input  logic              en0_n,
    input  logic              en1,
    input  logic              en2_n,
    input  logic              we,
    input  logic              adv,
    input  logic [NBYTE-1:0]  byte_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lin_order,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBYTE-1:0]  cmd_be
);

    localparam int HI_W = ADDR_W - 2;

    logic            selected;
    op_e             new_op;
    logic            active_q;
    op_e             bop_q;
    logic [HI_W-1:0] hi_q;
    logic [1:0]      base_q;
    logic [1:0]      cnt_q;
    logic [1:0]      cnt_nxt;

    // Device select needs all three enables at their active levels.
    assign selected = !en0_n && en1 && !en2_n;
    // Operation type of a freshly started access.
    assign new_op   = we ? OP_WR : OP_RD;
    // Beat counter for the next burst step, wrapping modulo four.
    assign cnt_nxt  = cnt_q + 2'd1;

    // Resolve the command of this edge: sleep, burst step, new access or deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_op   <= OP_NOP;
            cmd_addr <= '0;
            cmd_be   <= '0;
            active_q <= 1'b0;
            bop_q    <= OP_NOP;
            hi_q     <= '0;
            base_q   <= '0;
            cnt_q    <= '0;
        end else if (clk_en) begin
            if (sleep) begin
                cmd_op   <= OP_NOP;
                active_q <= 1'b0;
            end else if (adv) begin
                if (active_q) begin
                    cnt_q    <= cnt_nxt;
                    cmd_op   <= bop_q;
                    cmd_addr <= {hi_q, burst_offset(base_q, cnt_nxt, lin_order)};
                    cmd_be   <= byte_we;
                end else begin
                    cmd_op <= OP_NOP;
                end
            end else if (selected) begin
                cmd_op   <= new_op;
                cmd_addr <= addr;
                cmd_be   <= byte_we;
                bop_q    <= new_op;
                hi_q     <= addr[ADDR_W-1:2];
                base_q   <= addr[1:0];
                cnt_q    <= 2'd0;
                active_q <= 1'b1;
            end else begin
                cmd_op   <= OP_NOP;
                active_q <= 1'b0;
            end
        end
    end

    // R12
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_be)));

    // R14
    sleep_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && sleep) |=> (cmd_op == OP_NOP));

    // R1
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !sleep && !adv && selected) |=> (cmd_addr == $past(addr)));

endmodule

// File: rtl/zt_write_path.sv
// Late-write stage. It delays each write beat by zero (flow-through) or one
// (pipelined) extra enabled edge, takes wdata on that edge, drives the array
// lane strobes and checks the parity of each enabled 9-bit lane.
// Assumes flow_mode does not change while accesses are in flight.
module zt_write_path
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTE  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    flow_mode,
    input  logic                    par_odd,
    input  op_e                     cmd_op,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [NBYTE-1:0]        cmd_be,
    input  logic [NBYTE*BYTE_W-1:0] wdata,
    output logic [NBYTE-1:0]        mem_we,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [NBYTE*BYTE_W-1:0] mem_wdata,
    output logic                    par_err
);

    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [NBYTE-1:0]  s2_be;
    op_e               late_op;
    logic [NBYTE-1:0]  late_be;
    logic              capture;
    logic [NBYTE-1:0]  lane_bad;

    // Extra delay stage used by the double late write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op   <= OP_NOP;
            s2_addr <= '0;
            s2_be   <= '0;
        end else if (clk_en) begin
            s2_op   <= cmd_op;
            s2_addr <= cmd_addr;
            s2_be   <= cmd_be;
        end
    end

    // Pick the beat whose data is due on this edge.
    always_comb begin
        late_op  = flow_mode ? cmd_op   : s2_op;
        mem_addr = flow_mode ? cmd_addr : s2_addr;
        late_be  = flow_mode ? cmd_be   : s2_be;
    end

    assign capture   = clk_en && (late_op == OP_WR);
    assign mem_wdata = wdata;

    // One strobe and one parity checker per lane.
    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        assign mem_we[b]   = capture && late_be[b];
        assign lane_bad[b] = late_be[b] && ((^wdata[b*BYTE_W +: BYTE_W]) != par_odd);
    end

    // Parity flag reflects only the most recent enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_err <= 1'b0;
        end else if (clk_en) begin
            par_err <= capture && (|lane_bad);
        end
    end

    // R11
    par_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && late_op != OP_WR) |=> !par_err);

endmodule

// File: rtl/zt_array.sv
// Storage array: one memory per byte lane, per-lane synchronous write,
// asynchronous read. Contents are not reset.
module zt_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTE  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic [NBYTE-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [NBYTE*BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [NBYTE*BYTE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        // Write one lane when its strobe is set.
        always_ff @(posedge clk) begin
            if (we[b]) lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
        end

        assign rdata[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/zt_read_path.sv
// Read data path: output register with write forwarding for pipelined mode,
// direct array path for flow-through mode, and asynchronous output gating.
// Assumes flow_mode is static and the array read is combinational.
module zt_read_path
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTE  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    flow_mode,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  op_e                     cmd_op,
    input  logic [ADDR_W-1:0]       cmd_addr,
    input  logic [NBYTE*BYTE_W-1:0] arr_rdata,
    input  logic [NBYTE-1:0]        mem_we,
    input  logic [ADDR_W-1:0]       mem_addr,
    input  logic [NBYTE*BYTE_W-1:0] mem_wdata,
    output logic [NBYTE*BYTE_W-1:0] rdata,
    output logic                    rd_drive
);

    localparam int DATA_W = NBYTE * BYTE_W;

    logic [DATA_W-1:0] merged;
    logic              addr_hit;
    logic [DATA_W-1:0] q_data;
    logic              q_valid;
    logic              src_valid;
    logic [DATA_W-1:0] src_data;

    assign addr_hit = (mem_addr == cmd_addr);

    // Lanes being written on this edge to the word being read come from wdata.
    for (genvar b = 0; b < NBYTE; b++) begin : g_fwd
        assign merged[b*BYTE_W +: BYTE_W] = (mem_we[b] && addr_hit)
            ? mem_wdata[b*BYTE_W +: BYTE_W]
            : arr_rdata[b*BYTE_W +: BYTE_W];
    end

    // Output register for the pipelined variant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else if (clk_en) begin
            q_valid <= (cmd_op == OP_RD);
            q_data  <= merged;
        end
    end

    // Select the data source for the active mode and gate the bus drivers.
    always_comb begin
        src_valid = flow_mode ? (cmd_op == OP_RD) : q_valid;
        src_data  = flow_mode ? arr_rdata : q_data;
        rd_drive  = src_valid && !oe_n && !sleep;
        rdata     = rd_drive ? src_data : '0;
    end

    // R2
    pipe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !flow_mode && cmd_op != OP_RD) |=> !q_valid);

    // R6
    fwd_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !flow_mode && cmd_op == OP_RD && mem_we[0] && addr_hit)
        |=> (q_data[BYTE_W-1:0] == $past(mem_wdata[BYTE_W-1:0])));

endmodule

// File: rtl/zt_sram.sv
// Top level of the zero-turnaround synchronous SRAM model. Connects the
// command/burst stage, late-write stage, storage array and read path.
// Assumes flow_mode and lin_order are tied off for the whole run.
module zt_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTE  = 2,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en,
    input  logic                      en0_n,
    input  logic                      en1,
    input  logic                      en2_n,
    input  logic                      we,
    input  logic                      adv,
    input  logic [NBYTE-1:0]          byte_we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NBYTE*BYTE_W-1:0]   wdata,
    input  logic                      oe_n,
    input  logic                      sleep,
    input  logic                      flow_mode,
    input  logic                      lin_order,
    input  logic                      par_odd,
    output logic [NBYTE*BYTE_W-1:0]   rdata,
    output logic                      rd_drive,
    output logic                      par_err
);

    localparam int DATA_W = NBYTE * BYTE_W;

    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [NBYTE-1:0]  cmd_be;
    logic [NBYTE-1:0]  mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] arr_rdata;

    zt_burst_ctl #(.ADDR_W(ADDR_W), .NBYTE(NBYTE)) burst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sleep     (sleep),
        .en0_n     (en0_n),
        .en1       (en1),
        .en2_n     (en2_n),
        .we        (we),
        .adv       (adv),
        .byte_we   (byte_we),
        .addr      (addr),
        .lin_order (lin_order),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_be    (cmd_be)
    );

    zt_write_path #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) wpath_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .flow_mode (flow_mode),
        .par_odd   (par_odd),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_be    (cmd_be),
        .wdata     (wdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .par_err   (par_err)
    );

    zt_array #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) array_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (cmd_addr),
        .rdata (arr_rdata)
    );

    zt_read_path #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) rpath_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .flow_mode (flow_mode),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .arr_rdata (arr_rdata),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rdata     (rdata),
        .rd_drive  (rd_drive)
    );

endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        en0_n = 1'b1;
    logic        en1 = 1'b0;
    logic        en2_n = 1'b1;
    logic        we = 1'b0;
    logic        adv = 1'b0;
    logic [1:0]  byte_we = 2'b00;
    logic [5:0]  addr = '0;
    logic [17:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic        flow_mode = 1'b0;
    logic        lin_order = 1'b1;
    logic        par_odd = 1'b0;
    logic [17:0] rdata;
    logic        rd_drive;
    logic        par_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    zt_sram dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .en0_n(en0_n), .en1(en1), .en2_n(en2_n),
        .we(we), .adv(adv), .byte_we(byte_we), .addr(addr), .wdata(wdata),
        .oe_n(oe_n), .sleep(sleep), .flow_mode(flow_mode),
        .lin_order(lin_order), .par_odd(par_odd),
        .rdata(rdata), .rd_drive(rd_drive), .par_err(par_err)
    );

    // Lane with parity bit on top so the 9-bit XOR equals odd.
    function automatic logic [8:0] mkb(input logic [7:0] v, input logic odd);
        return {(^v) ^ odd, v};
    endfunction

    function automatic logic [17:0] mkw(input logic [15:0] v, input logic odd);
        return {mkb(v[15:8], odd), mkb(v[7:0], odd)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic c_idle();
        en0_n = 1'b1; en1 = 1'b0; en2_n = 1'b1; we = 1'b0; adv = 1'b0;
    endtask

    task automatic c_rd(input logic [5:0] a);
        en0_n = 1'b0; en1 = 1'b1; en2_n = 1'b0; we = 1'b0; adv = 1'b0;
        addr = a; byte_we = 2'b00;
    endtask

    task automatic c_wr(input logic [5:0] a, input logic [1:0] be);
        en0_n = 1'b0; en1 = 1'b1; en2_n = 1'b0; we = 1'b1; adv = 1'b0;
        addr = a; byte_we = be;
    endtask

    // Burst step with enables deselected and we/addr scrambled: must be ignored.
    task automatic c_adv(input logic we_v);
        en0_n = 1'b1; en1 = 1'b0; en2_n = 1'b1; we = we_v; adv = 1'b1;
        addr = 6'h3F; byte_we = 2'b11;
    endtask

    task automatic do_reset(input logic flow, input logic lin);
        rst_n = 1'b0; flow_mode = flow; lin_order = lin;
        clk_en = 1'b1; oe_n = 1'b0; sleep = 1'b0; par_odd = 1'b0;
        c_idle();
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b1);
        chk("R2", "drive after reset", 32'(rd_drive), 32'd0);
        chk("R11", "par_err after reset", 32'(par_err), 32'd0);
    endtask

    task automatic t_pipe_rw();
        logic [17:0] d1 = mkw(16'hA15C, 1'b0);
        logic [17:0] d2 = mkw(16'h3E07, 1'b0);
        c_wr(6'd5, 2'b11); step();
        chk("R2", "no drive after write", 32'(rd_drive), 32'd0);
        c_wr(6'd6, 2'b11); step();
        c_rd(6'd5); wdata = d1; step();
        chk("R2", "read not yet driven", 32'(rd_drive), 32'd0);
        c_rd(6'd6); wdata = d2; step();
        chk("R2", "drive on first read", 32'(rd_drive), 32'd1);
        chk("R4", "data of addr5", 32'(rdata), 32'(d1));
        c_idle(); wdata = '0; step();
        chk("R4", "data of addr6", 32'(rdata), 32'(d2));
        step();
        chk("R2", "drive ends", 32'(rd_drive), 32'd0);
    endtask

    task automatic t_forward();
        logic [17:0] x = mkw(16'h5AC3, 1'b0);
        logic [17:0] y = mkw(16'h1E96, 1'b0);
        c_wr(6'd9, 2'b11); step();
        c_idle(); step();
        wdata = x; step();
        c_wr(6'd9, 2'b01); wdata = '0; step();
        c_rd(6'd9); step();
        c_idle(); wdata = y; step();
        chk("R6", "forwarded partial write", 32'(rdata), 32'({x[17:9], y[8:0]}));
        wdata = '0; step();
        c_rd(6'd9); step();
        c_idle(); step();
        chk("R10", "lane 1 kept in array", 32'(rdata), 32'({x[17:9], y[8:0]}));
    endtask

    task automatic t_flow();
        logic [17:0] f1 = mkw(16'hC001, 1'b0);
        do_reset(1'b1, 1'b1);
        c_wr(6'd3, 2'b11); step();
        chk("R5", "no drive after write", 32'(rd_drive), 32'd0);
        c_rd(6'd3); wdata = f1; step();
        chk("R3", "flow read drives at once", 32'(rd_drive), 32'd1);
        chk("R5", "single late write data", 32'(rdata), 32'(f1));
        c_idle(); wdata = '0; step();
        chk("R3", "flow drive one cycle", 32'(rd_drive), 32'd0);
        c_rd(6'd3); step();
        chk("R3", "flow reread", 32'(rdata), 32'(f1));
        c_idle(); step();
    endtask

    task automatic t_burst_lin();
        logic [17:0] d [4];
        for (int k = 0; k < 4; k++) d[k] = mkw(16'(16'h1100 * (k + 1) + k), 1'b0);
        do_reset(1'b0, 1'b1);
        c_wr(6'd10, 2'b11); step();
        c_adv(1'b0); step();
        c_adv(1'b0); wdata = d[0]; step();
        c_adv(1'b0); wdata = d[1]; step();
        c_idle(); wdata = d[2]; step();
        wdata = d[3]; step();
        wdata = '0; step();
        // Linear from offset 2: 10, 11, 8, 9.
        c_rd(6'd10); step();
        c_rd(6'd11); step();
        chk("R7", "beat0 at 10", 32'(rdata), 32'(d[0]));
        c_rd(6'd8); step();
        chk("R9", "beat1 at 11 kept write type", 32'(rdata), 32'(d[1]));
        c_rd(6'd9); step();
        chk("R7", "beat2 wraps to 8", 32'(rdata), 32'(d[2]));
        c_idle(); step();
        chk("R7", "beat3 at 9", 32'(rdata), 32'(d[3]));
    endtask

    task automatic t_burst_il();
        logic [17:0] v [4];
        for (int k = 0; k < 4; k++) v[k] = mkw(16'(16'h0A0B + 16'h2222 * k), 1'b0);
        do_reset(1'b0, 1'b0);
        c_wr(6'd8, 2'b11); step();
        c_wr(6'd9, 2'b11); step();
        c_wr(6'd10, 2'b11); wdata = v[0]; step();
        c_wr(6'd11, 2'b11); wdata = v[1]; step();
        c_idle(); wdata = v[2]; step();
        wdata = v[3]; step();
        wdata = '0;
        // Interleaved from offset 1: 9, 8, 11, 10.
        c_rd(6'd9); step();
        c_adv(1'b1); step();
        chk("R8", "beat0 at 9", 32'(rdata), 32'(v[1]));
        c_adv(1'b1); step();
        chk("R8", "beat1 at 8", 32'(rdata), 32'(v[0]));
        c_adv(1'b1); step();
        chk("R9", "beat2 at 11 stays read", 32'(rdata), 32'(v[3]));
        c_idle(); step();
        chk("R8", "beat3 at 10", 32'(rdata), 32'(v[2]));
        c_adv(1'b0); step();
        step();
        chk("R9", "adv without burst is deselect", 32'(rd_drive), 32'd0);
        c_idle();
    endtask

    task automatic t_parity();
        logic [17:0] good = mkw(16'h1234, 1'b0);
        logic [17:0] hbad = mkw(16'h5678, 1'b0) ^ 18'h20000;
        do_reset(1'b0, 1'b1);
        c_wr(6'd12, 2'b11); step();
        c_idle(); step();
        wdata = good; step();
        chk("R11", "even ok", 32'(par_err), 32'd0);
        c_wr(6'd13, 2'b01); wdata = '0; step();
        c_idle(); step();
        wdata = hbad; step();
        chk("R11", "bad disabled lane ignored", 32'(par_err), 32'd0);
        c_wr(6'd14, 2'b10); wdata = '0; step();
        c_idle(); step();
        wdata = hbad; step();
        chk("R11", "bad enabled lane flagged", 32'(par_err), 32'd1);
        wdata = '0; step();
        chk("R11", "flag clears", 32'(par_err), 32'd0);
        par_odd = 1'b1;
        c_wr(6'd15, 2'b11); step();
        c_idle(); step();
        wdata = mkw(16'h9ABC, 1'b1); step();
        chk("R11", "odd ok", 32'(par_err), 32'd0);
        c_wr(6'd16, 2'b11); wdata = '0; step();
        c_idle(); step();
        wdata = mkw(16'h9ABC, 1'b0); step();
        chk("R11", "even data under odd", 32'(par_err), 32'd1);
        par_odd = 1'b0; wdata = '0; step();
    endtask

    task automatic t_cke(output logic [17:0] c1);
        c1 = mkw(16'h7E81, 1'b0);
        c_wr(6'd20, 2'b11); step();
        c_idle(); step();
        wdata = c1; step();
        c_rd(6'd20); wdata = '0; step();
        c_idle(); step();
        chk("R12", "data before freeze", 32'(rdata), 32'(c1));
        clk_en = 1'b0; c_rd(6'd5); step();
        chk("R12", "held while frozen", 32'(rdata), 32'(c1));
        step();
        chk("R12", "still held", 32'(rd_drive), 32'd1);
        clk_en = 1'b1; c_idle(); step();
        chk("R12", "frozen reads lost (1)", 32'(rd_drive), 32'd0);
        step();
        chk("R12", "frozen reads lost (2)", 32'(rd_drive), 32'd0);
    endtask

    task automatic t_oe(input logic [17:0] c1);
        c_rd(6'd20); step();
        c_idle(); step();
        oe_n = 1'b1; #1;
        chk("R13", "oe off drive", 32'(rd_drive), 32'd0);
        chk("R13", "oe off data", 32'(rdata), 32'd0);
        oe_n = 1'b0; #1;
        chk("R13", "oe back", 32'(rdata), 32'(c1));
    endtask

    task automatic t_sleep();
        sleep = 1'b1; #1;
        chk("R14", "sleep drive off", 32'(rd_drive), 32'd0);
        @(negedge clk);
        c_rd(6'd20); step();
        sleep = 1'b0; c_idle(); step();
        chk("R14", "read during sleep dropped", 32'(rd_drive), 32'd0);
    endtask

    task automatic t_select(input logic [17:0] c1);
        for (int k = 0; k < 3; k++) begin
            c_rd(6'd20);
            if (k == 0) en0_n = 1'b1;
            if (k == 1) en1 = 1'b0;
            if (k == 2) en2_n = 1'b1;
            step();
            c_idle(); step();
            chk("R1", $sformatf("enable %0d inactive", k), 32'(rd_drive), 32'd0);
        end
        c_rd(6'd20); step();
        c_idle(); step();
        chk("R1", "all enables active", 32'(rdata), 32'(c1));
    endtask

    initial begin
        logic [17:0] c1;
        t_reset();
        t_pipe_rw();
        t_forward();
        t_flow();
        t_burst_lin();
        t_burst_il();
        t_parity();
        t_cke(c1);
        t_oe(c1);
        t_sleep();
        t_select(c1);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule